// File: doc/BRIEF.md
# Eight-bit ALU with condition-code update

This block is the arithmetic and logic stage of a small accumulator-style processor. Each cycle it takes an operation code, two operands and the current condition-code byte. It returns a result, a write-back enable and the next condition-code byte. Operand A is the accumulator and the only source for single-operand operations. Operand B is the second source for two-operand operations. Every operation has its own rule for which flags it touches. Decoding, registers, memory and addressing are left to the surrounding core.

The condition-code byte is laid out as `{1, 1, H, I, N, Z, V, C}`, with C in bit 0. Its two top bits always read 1. The interrupt-mask bit I is carried through untouched. Outputs are registered: inputs presented before a rising clock edge appear on the outputs after that edge.

The result is 16 bits wide. The product of a multiply fills all 16 bits. Every other operation puts its value in the low byte and zero in the high byte. `result` always shows the computed value, even when `writeEn` is low.

Top module: `aluCcUnit`

## Requirements
- R1: While `rstN` is low, the outputs are `result`=0, `writeEn`=0 and `ccOut`=0xC0. Outputs change only on the rising clock edge that samples the inputs.
- R2: `ccOut` bits 7:6 are always 1. Bit 4 (I) always equals bit 4 of `ccIn`.
- R3: Add (code 0) returns A+B. Add-with-carry (code 1) returns A+B+C. Both set C from the carry out of bit 7 and H (bit 5) from the carry out of bit 3. V is set when the carry into bit 7 differs from the carry out of bit 7. N copies result bit 7, and Z is set when the low result byte is zero.
- R4: Subtract (code 2) returns A-B. Subtract-with-borrow (code 3) returns A-B-C. Compare (code 4) computes A-B but drives `writeEn`=0. All three set C on a borrow into bit 7 and update N, Z and V.
- R5: Increment (code 5) and decrement (code 6) act on A and update N, Z and V. They keep C and H.
- R6: Clear (code 7) returns 0 with N=0, Z=1, V=0, C=0. Complement (code 8) returns ~A with C=1, V=0, and N and Z updated.
- R7: Negate (code 9) returns 0-A. It sets V only for A=0x80, and the result is then 0x80. It sets C exactly when A is nonzero.
- R8: Test (code 10) updates N and Z from A, clears V and C, and drives `writeEn`=0. AND (11), bit-test (12), OR (13) and XOR (14) update N and Z, clear V and keep C. Bit-test drives `writeEn`=0.
- R9: Each of these acts on A and sends the bit shifted out to C:
  - rotate left (15) fills bit 0 with C;
  - rotate right (16) fills bit 7 with C;
  - logical right (17) fills bit 7 with 0;
  - arithmetic left (18) fills bit 0 with 0;
  - arithmetic right (19) keeps bit 7.

  In all five, V is set when bit 7 changes value, and N and Z are updated.
- R10: Multiply (code 20) returns the 16-bit unsigned product A*B. It changes only C, which is set from product bit 7.
- R11: Codes 21 to 31 drive `writeEn`=0. They pass `ccIn` bits 5:0 through unchanged, and `result` is A.
- R12: H changes only on codes 0 and 1. Every other code keeps it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| opSel | input | 5 | Operation code |
| opA | input | 8 | Accumulator operand |
| opB | input | 8 | Second operand |
| ccIn | input | 8 | Current condition-code byte |
| result | output | 16 | Computed value (product, or zero-extended byte) |
| writeEn | output | 1 | Result should be written back |
| ccOut | output | 8 | Next condition-code byte |

## Verification
The bound checker checks some rules on every cycle against the inputs of the previous cycle:
- the forced top bits and the pass-through of the I bit;
- C held across increment and decrement;
- the overflow rule of negate, with V only at 0x80;
- the product and its carry bit;
- write-back suppressed for compare, bit-test and test;
- H held outside the add operations;
- full flag pass-through for the unassigned codes.

Only the bench's vectors show the exact arithmetic flags, because they need hand-worked expected bytes:
- half carry and signed overflow on addition;
- borrow on subtraction with and without an incoming carry;
- the fill bit and V of each shift and rotate;
- the zero and sign cases of clear, complement and negate.

The bench alone covers reset while the block is running and the one-cycle output latency.

// File: rtl/aluPkg.sv
package aluPkg;

  localparam int CC_W = 8;
  localparam int CC_C = 0;
  localparam int CC_V = 1;
  localparam int CC_Z = 2;
  localparam int CC_N = 3;
  localparam int CC_I = 4;
  localparam int CC_H = 5;

  typedef enum logic [4:0] {
    OP_ADD  = 5'd0,
    OP_ADC  = 5'd1,
    OP_SUB  = 5'd2,
    OP_SBC  = 5'd3,
    OP_CMP  = 5'd4,
    OP_INC  = 5'd5,
    OP_DEC  = 5'd6,
    OP_CLR  = 5'd7,
    OP_COM  = 5'd8,
    OP_NEG  = 5'd9,
    OP_TST  = 5'd10,
    OP_AND  = 5'd11,
    OP_BIT  = 5'd12,
    OP_ORA  = 5'd13,
    OP_EOR  = 5'd14,
    OP_ROL  = 5'd15,
    OP_ROR  = 5'd16,
    OP_LSR  = 5'd17,
    OP_ASL  = 5'd18,
    OP_ASR  = 5'd19,
    OP_MUL  = 5'd20,
    OP_PASS = 5'd31
  } aluOp_e;

  localparam logic [4:0] LAST_OP = 5'd20;

  // Strobes from control to datapath and flag merge
  typedef struct packed {
    aluOp_e fn;
    logic   wb;
    logic   updH;
    logic   updN;
    logic   updZ;
    logic   updV;
    logic   updC;
  } aluStrobe_t;

endpackage

// File: rtl/aluCtrl.sv
module aluCtrl
  import aluPkg::*;
(
  input  logic [4:0]  opSel,
  output aluStrobe_t  strobe
);

  always_comb begin
    strobe = '0;
    if (opSel <= LAST_OP) strobe.fn = aluOp_e'(opSel);
    else                  strobe.fn = OP_PASS;
    case (strobe.fn)
      OP_ADD, OP_ADC: begin
        strobe.wb = 1'b1;
        strobe.updH = 1'b1;
        strobe.updN = 1'b1;
        strobe.updZ = 1'b1;
        strobe.updV = 1'b1;
        strobe.updC = 1'b1;
      end
      OP_SUB, OP_SBC, OP_CLR, OP_COM, OP_NEG,
      OP_ROL, OP_ROR, OP_LSR, OP_ASL, OP_ASR: begin
        strobe.wb = 1'b1;
        strobe.updN = 1'b1;
        strobe.updZ = 1'b1;
        strobe.updV = 1'b1;
        strobe.updC = 1'b1;
      end
      OP_CMP, OP_TST: begin
        strobe.updN = 1'b1;
        strobe.updZ = 1'b1;
        strobe.updV = 1'b1;
        strobe.updC = 1'b1;
      end
      OP_INC, OP_DEC, OP_AND, OP_ORA, OP_EOR: begin
        strobe.wb = 1'b1;
        strobe.updN = 1'b1;
        strobe.updZ = 1'b1;
        strobe.updV = 1'b1;
      end
      OP_BIT: begin
        strobe.updN = 1'b1;
        strobe.updZ = 1'b1;
        strobe.updV = 1'b1;
      end
      OP_MUL: begin
        strobe.wb = 1'b1;
        strobe.updC = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/aluDatapath.sv
module aluDatapath
  import aluPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  aluOp_e                 fn,
  input  logic [DATA_W-1:0]      a,
  input  logic [DATA_W-1:0]      b,
  input  logic                   cIn,
  output logic [2*DATA_W-1:0]    res,
  output logic                   candH,
  output logic                   candN,
  output logic                   candZ,
  output logic                   candV,
  output logic                   candC
);

  localparam int MSB  = DATA_W - 1;
  localparam int HB   = DATA_W / 2;
  localparam int PR_W = 2 * DATA_W;

  // Shared adder: x + y + c0
  logic [MSB:0]    addX, addY;
  logic            addC0, borrowMode;
  logic [DATA_W:0] addSum;
  logic [MSB:0]    lowSum;
  logic [HB:0]     halfSum;
  logic            carryIntoTop, carryOut;

  always_comb begin
    addX = a;
    addY = b;
    addC0 = 1'b0;
    borrowMode = 1'b0;
    case (fn)
      OP_ADC: addC0 = cIn;
      OP_SUB, OP_CMP: begin addY = ~b; addC0 = 1'b1; borrowMode = 1'b1; end
      OP_SBC: begin addY = ~b; addC0 = ~cIn; borrowMode = 1'b1; end
      OP_INC: begin addY = '0; addC0 = 1'b1; end
      OP_DEC: begin addY = '1; addC0 = 1'b0; end
      OP_NEG: begin addX = '0; addY = ~a; addC0 = 1'b1; borrowMode = 1'b1; end
      default: ;
    endcase
  end

  assign addSum  = {1'b0, addX} + {1'b0, addY} + {{DATA_W{1'b0}}, addC0};
  assign lowSum  = {1'b0, addX[MSB-1:0]} + {1'b0, addY[MSB-1:0]} + {{MSB{1'b0}}, addC0};
  assign halfSum = {1'b0, addX[HB-1:0]} + {1'b0, addY[HB-1:0]} + {{HB{1'b0}}, addC0};
  assign carryIntoTop = lowSum[MSB];
  assign carryOut     = addSum[DATA_W];

  // Shift and rotate unit
  logic [MSB:0] shRes;
  logic         shOut;

  always_comb begin
    shRes = a;
    shOut = 1'b0;
    case (fn)
      OP_ROL: begin shRes = {a[MSB-1:0], cIn};  shOut = a[MSB]; end
      OP_ROR: begin shRes = {cIn, a[MSB:1]};    shOut = a[0];   end
      OP_LSR: begin shRes = {1'b0, a[MSB:1]};   shOut = a[0];   end
      OP_ASL: begin shRes = {a[MSB-1:0], 1'b0}; shOut = a[MSB]; end
      OP_ASR: begin shRes = {a[MSB], a[MSB:1]}; shOut = a[0];   end
      default: ;
    endcase
  end

  logic [PR_W-1:0] product;
  assign product = {{DATA_W{1'b0}}, a} * {{DATA_W{1'b0}}, b};

  // Result and candidate flags
  logic [MSB:0] byteRes;

  always_comb begin
    byteRes = a;
    candH = halfSum[HB];
    candV = 1'b0;
    candC = cIn;
    case (fn)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP, OP_INC, OP_DEC, OP_NEG: begin
        byteRes = addSum[MSB:0];
        candV = carryIntoTop ^ carryOut;
        candC = borrowMode ? ~carryOut : carryOut;
      end
      OP_CLR: begin byteRes = '0; candC = 1'b0; end
      OP_COM: begin byteRes = ~a; candC = 1'b1; end
      OP_TST: candC = 1'b0;
      OP_AND, OP_BIT: byteRes = a & b;
      OP_ORA: byteRes = a | b;
      OP_EOR: byteRes = a ^ b;
      OP_ROL, OP_ROR, OP_LSR, OP_ASL, OP_ASR: begin
        byteRes = shRes;
        candC = shOut;
        candV = shRes[MSB] ^ a[MSB];
      end
      OP_MUL: candC = product[MSB];
      default: ;
    endcase
  end

  assign candN = byteRes[MSB];
  assign candZ = (byteRes == '0);
  assign res   = (fn == OP_MUL) ? product : {{DATA_W{1'b0}}, byteRes};

endmodule

// File: rtl/aluCcUnit.sv
module aluCcUnit
  import aluPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [4:0]          opSel,
  input  logic [DATA_W-1:0]   opA,
  input  logic [DATA_W-1:0]   opB,
  input  logic [CC_W-1:0]     ccIn,
  output logic [2*DATA_W-1:0] result,
  output logic                writeEn,
  output logic [CC_W-1:0]     ccOut
);

  localparam logic [CC_W-1:0] CC_RESET = 8'hC0;

  aluStrobe_t          strobe;
  logic [2*DATA_W-1:0] dpRes;
  logic                candH, candN, candZ, candV, candC;
  logic [CC_W-1:0]     nextCc;

  aluCtrl ctrl_i (
    .opSel  (opSel),
    .strobe (strobe)
  );

  aluDatapath #(.DATA_W(DATA_W)) dp_i (
    .fn    (strobe.fn),
    .a     (opA),
    .b     (opB),
    .cIn   (ccIn[CC_C]),
    .res   (dpRes),
    .candH (candH),
    .candN (candN),
    .candZ (candZ),
    .candV (candV),
    .candC (candC)
  );

  always_comb begin
    nextCc       = ccIn;
    nextCc[7:6]  = 2'b11;
    if (strobe.updH) nextCc[CC_H] = candH;
    if (strobe.updN) nextCc[CC_N] = candN;
    if (strobe.updZ) nextCc[CC_Z] = candZ;
    if (strobe.updV) nextCc[CC_V] = candV;
    if (strobe.updC) nextCc[CC_C] = candC;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result  <= '0;
      writeEn <= 1'b0;
      ccOut   <= CC_RESET;
    end else begin
      result  <= dpRes;
      writeEn <= strobe.wb;
      ccOut   <= nextCc;
    end
  end

endmodule

// File: rtl/aluCcChecker.sv
module aluCcChecker
  import aluPkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic [4:0]          opSel,
  input logic [DATA_W-1:0]   opA,
  input logic [DATA_W-1:0]   opB,
  input logic [CC_W-1:0]     ccIn,
  input logic [2*DATA_W-1:0] result,
  input logic                writeEn,
  input logic [CC_W-1:0]     ccOut
);

  localparam logic [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};

  logic primed;
  logic [2*DATA_W-1:0] prodChk;
  assign prodChk = {{DATA_W{1'b0}}, opA} * {{DATA_W{1'b0}}, opB};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) primed <= 1'b0;
    else       primed <= 1'b1;
  end

  p_top_ones_r2: assert property (@(posedge clk) disable iff (!rstN)
    ccOut[7:6] == 2'b11);

  p_i_kept_r2: assert property (@(posedge clk) disable iff (!rstN)
    primed |-> ccOut[CC_I] == $past(ccIn[CC_I]));

  p_no_wb_cmp_r4: assert property (@(posedge clk) disable iff (!rstN)
    primed && $past(opSel) == OP_CMP |-> !writeEn);

  p_keep_c_r5: assert property (@(posedge clk) disable iff (!rstN)
    primed && ($past(opSel) == OP_INC || $past(opSel) == OP_DEC)
      |-> ccOut[CC_C] == $past(ccIn[CC_C]));

  p_neg_ovf_r7: assert property (@(posedge clk) disable iff (!rstN)
    primed && $past(opSel) == OP_NEG |-> ccOut[CC_V] == ($past(opA) == MOST_NEG));

  p_neg_carry_r7: assert property (@(posedge clk) disable iff (!rstN)
    primed && $past(opSel) == OP_NEG |-> ccOut[CC_C] == ($past(opA) != '0));

  p_no_wb_test_r8: assert property (@(posedge clk) disable iff (!rstN)
    primed && ($past(opSel) == OP_BIT || $past(opSel) == OP_TST) |-> !writeEn);

  p_mul_r10: assert property (@(posedge clk) disable iff (!rstN)
    primed && $past(opSel) == OP_MUL
      |-> result == $past(prodChk) && ccOut[CC_C] == $past(prodChk[DATA_W-1])
          && ccOut[5:1] == $past(ccIn[5:1]));

  p_pass_r11: assert property (@(posedge clk) disable iff (!rstN)
    primed && $past(opSel) > LAST_OP
      |-> !writeEn && ccOut[5:0] == $past(ccIn[5:0]));

  p_h_kept_r12: assert property (@(posedge clk) disable iff (!rstN)
    primed && $past(opSel) != OP_ADD && $past(opSel) != OP_ADC
      |-> ccOut[CC_H] == $past(ccIn[CC_H]));

  p_zero_add_r3: assert property (@(posedge clk) disable iff (!rstN)
    primed && $past(opSel) == OP_ADD |-> ccOut[CC_Z] == (result[DATA_W-1:0] == '0));

endmodule

bind aluCcUnit aluCcChecker #(.DATA_W(DATA_W)) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .opSel   (opSel),
  .opA     (opA),
  .opB     (opB),
  .ccIn    (ccIn),
  .result  (result),
  .writeEn (writeEn),
  .ccOut   (ccOut)
);

// File: tb/aluCcUnit_tb_top.sv
module aluCcUnit_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  opSel = '0;
  logic [7:0]  opA = '0;
  logic [7:0]  opB = '0;
  logic [7:0]  ccIn = '0;
  logic [15:0] result;
  logic        writeEn;
  logic [7:0]  ccOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  aluCcUnit dut_i (
    .clk     (clk),
    .rstN    (rstN),
    .opSel   (opSel),
    .opA     (opA),
    .opB     (opB),
    .ccIn    (ccIn),
    .result  (result),
    .writeEn (writeEn),
    .ccOut   (ccOut)
  );

  // {req[3:0], op[4:0], a, b, ccIn, expResult[15:0], expWe, expCc}
  localparam int NV = 32;
  localparam logic [57:0] VECS [0:NV-1] = '{
    {4'd3,  5'd0,  8'hC8, 8'h96, 8'hC0, 16'h005E, 1'b1, 8'hC3}, // R3 carry + overflow
    {4'd3,  5'd0,  8'h18, 8'h09, 8'hC0, 16'h0021, 1'b1, 8'hE0}, // R3 half carry
    {4'd3,  5'd1,  8'h7F, 8'h00, 8'hC1, 16'h0080, 1'b1, 8'hEA}, // R3 carry in
    {4'd4,  5'd2,  8'h19, 8'hC5, 8'hC0, 16'h0054, 1'b1, 8'hC1}, // R4 borrow
    {4'd4,  5'd2,  8'h9C, 8'h32, 8'hC0, 16'h006A, 1'b1, 8'hC2}, // R4 signed overflow
    {4'd4,  5'd3,  8'h50, 8'h20, 8'hC1, 16'h002F, 1'b1, 8'hC0}, // R4 borrow in
    {4'd4,  5'd4,  8'h42, 8'h42, 8'hC0, 16'h0000, 1'b0, 8'hC4}, // R4 compare equal
    {4'd4,  5'd4,  8'h1A, 8'h1B, 8'hC0, 16'h00FF, 1'b0, 8'hC9}, // R4 compare lower
    {4'd5,  5'd5,  8'h7F, 8'h55, 8'hE1, 16'h0080, 1'b1, 8'hEB}, // R5 inc overflow
    {4'd5,  5'd6,  8'h00, 8'h00, 8'hC0, 16'h00FF, 1'b1, 8'hC8}, // R5 dec wrap
    {4'd5,  5'd6,  8'h80, 8'h00, 8'hC1, 16'h007F, 1'b1, 8'hC3}, // R5 dec overflow
    {4'd6,  5'd7,  8'h5A, 8'h00, 8'hCB, 16'h0000, 1'b1, 8'hC4}, // R6 clear
    {4'd6,  5'd8,  8'hFF, 8'h00, 8'hC0, 16'h0000, 1'b1, 8'hC5}, // R6 complement
    {4'd7,  5'd9,  8'h80, 8'h00, 8'hC0, 16'h0080, 1'b1, 8'hCB}, // R7 negate 0x80
    {4'd7,  5'd9,  8'h00, 8'h00, 8'hC1, 16'h0000, 1'b1, 8'hC4}, // R7 negate zero
    {4'd7,  5'd9,  8'h01, 8'h00, 8'hC0, 16'h00FF, 1'b1, 8'hC9}, // R7 negate one
    {4'd8,  5'd10, 8'h80, 8'h00, 8'hC3, 16'h0080, 1'b0, 8'hC8}, // R8 test
    {4'd8,  5'd11, 8'hF0, 8'h3C, 8'hC3, 16'h0030, 1'b1, 8'hC1}, // R8 and keeps C
    {4'd8,  5'd12, 8'h0F, 8'hF0, 8'hC0, 16'h0000, 1'b0, 8'hC4}, // R8 bit-test
    {4'd8,  5'd13, 8'h80, 8'h01, 8'hC1, 16'h0081, 1'b1, 8'hC9}, // R8 or
    {4'd8,  5'd14, 8'hAA, 8'hAA, 8'hC2, 16'h0000, 1'b1, 8'hC4}, // R8 xor clears V
    {4'd9,  5'd15, 8'h80, 8'h00, 8'hC1, 16'h0001, 1'b1, 8'hC3}, // R9 rotate left
    {4'd9,  5'd16, 8'h01, 8'h00, 8'hC0, 16'h0000, 1'b1, 8'hC5}, // R9 rotate right zero
    {4'd9,  5'd16, 8'h02, 8'h00, 8'hC1, 16'h0081, 1'b1, 8'hCA}, // R9 rotate right C in
    {4'd9,  5'd17, 8'h81, 8'h00, 8'hC0, 16'h0040, 1'b1, 8'hC3}, // R9 logical right
    {4'd9,  5'd18, 8'h40, 8'h00, 8'hC1, 16'h0080, 1'b1, 8'hCA}, // R9 shift left
    {4'd9,  5'd19, 8'h81, 8'h00, 8'hC0, 16'h00C0, 1'b1, 8'hC9}, // R9 arithmetic right
    {4'd10, 5'd20, 8'hFF, 8'hFF, 8'hCF, 16'hFE01, 1'b1, 8'hCE}, // R10 multiply max
    {4'd10, 5'd20, 8'h10, 8'h08, 8'hC0, 16'h0080, 1'b1, 8'hC1}, // R10 multiply C set
    {4'd11, 5'd25, 8'h12, 8'h34, 8'hD5, 16'h0012, 1'b0, 8'hD5}, // R11 unassigned code
    {4'd2,  5'd0,  8'h01, 8'h01, 8'hD0, 16'h0002, 1'b1, 8'hD0}, // R2 I kept, R12 H from add
    {4'd2,  5'd31, 8'h00, 8'h00, 8'h00, 16'h0000, 1'b0, 8'hC0}  // R2 top bits forced
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    // R1: reset state
    @(negedge clk);
    @(negedge clk);
    check("R1 result in reset", result, 16'h0000);
    check("R1 writeEn in reset", {15'd0, writeEn}, 16'h0000);
    check("R1 ccOut in reset", {8'd0, ccOut}, 16'h00C0);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [57:0] v;
      string tag;
      v = VECS[i];
      opSel = v[53:49];
      opA   = v[48:41];
      opB   = v[40:33];
      ccIn  = v[32:25];
      @(negedge clk);
      tag = $sformatf("R%0d vec %0d", v[57:54], i);
      check({tag, " result"}, result, v[24:9]);
      check({tag, " writeEn"}, {15'd0, writeEn}, {15'd0, v[8]});
      check({tag, " ccOut"}, {8'd0, ccOut}, {8'd0, v[7:0]});
    end

    // R1: output holds until the sampling edge (last vector left writeEn=0)
    opSel = 5'd0; opA = 8'h01; opB = 8'h01; ccIn = 8'hC0;
    #2;
    check("R1 held before edge", {15'd0, writeEn}, 16'h0000);
    @(negedge clk);
    check("R1 updated after edge", result, 16'h0002);

    // R12: H kept by subtract even when low nibbles would carry
    opSel = 5'd2; opA = 8'h0F; opB = 8'h01; ccIn = 8'hE0;
    @(negedge clk);
    check("R12 H kept on subtract", {8'd0, ccOut}, 16'h00E0);

    // R1: reset while running
    opSel = 5'd0; opA = 8'h80; opB = 8'h80; ccIn = 8'hC0;
    @(negedge clk);
    rstN = 1'b0;
    #1;
    check("R1 mid-run reset result", result, 16'h0000);
    check("R1 mid-run reset ccOut", {8'd0, ccOut}, 16'h00C0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule